// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block owns the fetch program counter of a simple 16-bit-instruction sequencer and adds one level of hardware looping to it. A setup command gives the address of the setup instruction, two byte displacements and an iteration count. From these the block derives the first and last addresses of the loop body. Each time the fetch counter reaches the last address, it jumps back to the first address until the count is used up. Then it continues at the address that follows the body.

Instruction memory answers one cycle after a fetch request. The block keeps the first four instructions of the body in a small replay store. On later passes those instructions come from the store and not from memory. A body of four or fewer instructions therefore needs no memory traffic at all after its first pass. In a longer body, the fetches of the fifth and later instructions take place while the stored instructions are being issued.

A single `adv` input moves the pipeline on by one instruction. When `adv` is low, the fetch counter, the loop counter and the issue slot all hold.

Top module: `loop_seq`

## Requirements
- R1: After reset, `fetch_addr` equals RESET_PC (default 0), `instr_valid` is 0 and `setup_err` is 0.
- R2: With no loop armed, each cycle with `adv` high fetches at `fetch_addr` and moves the fetch address on by 2. The issued instruction appears on `instr`/`instr_pc` with `instr_valid` in the following cycle.
- R3: A setup is legal when all three of these hold: the start displacement (6-bit two's complement, in bytes) is even and in 0..30; the end displacement (12-bit two's complement, in bytes) is even and in 0..2046; the end displacement is not below the start displacement. The loop top is `setup_pc` plus the start displacement, and the loop bottom is `setup_pc` plus the end displacement.
- R4: An illegal setup raises `setup_err` for one cycle, one cycle after the request, and changes no loop state.
- R5: A legal setup with count N of 2 or more issues the body N times in address order, then falls through to bottom+2.
- R6: A legal setup with count 0 or 1 lets the body execute exactly once, as straight-line code.
- R7: `next_pc` is the address fetched in the next `adv` cycle. At the bottom it is the top (or bottom+2 on the last pass), and an issued instruction follows every `adv` cycle with no bubble at the loop boundary.
- R8: For a body of one to four instructions, no fetch request is issued on any pass after the first.
- R9: For a longer body, the first four instructions of passes two onward come from the replay store, and every later instruction is fetched. The number of fetches is therefore the number of issues minus (N-1)*4.
- R10: Accepting a new setup, or finishing a loop, empties the replay store, so the next loop's first pass fetches its body from memory.
- R11: While `adv` is low, the fetch address and the loop counter hold, `instr_valid` goes low, and the issued sequence is the same as without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Advance: fetch at the current address this cycle |
| setup_valid | input | 1 | Loop setup request |
| setup_pc | input | AW | Address of the setup instruction |
| setup_top_off | input | 6 | Signed byte displacement to the loop top |
| setup_bot_off | input | 12 | Signed byte displacement to the loop bottom |
| setup_count | input | CW | Iteration count |
| setup_err | output | 1 | Rejected setup, one cycle after the request |
| fetch_req | output | 1 | Memory read at fetch_addr this cycle |
| fetch_addr | output | AW | Current fetch address |
| mem_rdata | input | IW | Memory data for the previous cycle's request |
| next_pc | output | AW | Fetch address for the next advancing cycle |
| instr_valid | output | 1 | An instruction is issued this cycle |
| instr_pc | output | AW | Address of the issued instruction |
| instr | output | IW | Issued instruction (from memory or replay store) |

## Verification
On every cycle, the assertions check straight-line stepping, holding under stall, the jump from bottom to top, the fall-through with loop disarm on the last pass, and that a rejected setup leaves the boundaries untouched. Only the bench's scenarios can show the effects that build up over many cycles. These are: the exact issued address and instruction stream across all passes; the number of memory fetches, which shows replay-store use for short, exactly-four and long bodies; and that the store is emptied between loops. The bench memory returns a poison value whenever no fetch was requested, so a replay from a stale or missing entry shows up as a wrong instruction.

// File: rtl/loop_seq.sv
module loop_seq #(
  parameter int AW       = 16,
  parameter int IW       = 16,
  parameter int CW       = 16,
  parameter int BUF_N    = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          setup_valid,
  input  logic [AW-1:0] setup_pc,
  input  logic [5:0]    setup_top_off,
  input  logic [11:0]   setup_bot_off,
  input  logic [CW-1:0] setup_count,
  output logic          setup_err,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic [IW-1:0] mem_rdata,
  output logic [AW-1:0] next_pc,
  output logic          instr_valid,
  output logic [AW-1:0] instr_pc,
  output logic [IW-1:0] instr
);
  localparam int BW = (BUF_N > 1) ? $clog2(BUF_N) : 1;
  localparam logic [AW-1:0] WIN = AW'(2 * BUF_N);

  logic [AW-1:0] fpc, top_q, bot_q, ipc;
  logic [CW-1:0] cnt;
  logic          active;
  logic [IW-1:0] lbuf [BUF_N];
  logic [BUF_N-1:0] bv;
  logic          ivalid, ihit, ifill;
  logic [BW-1:0] iidx;

  wire top_ok   = !setup_top_off[5] && !setup_top_off[0];
  wire bot_ok   = !setup_bot_off[11] && !setup_bot_off[0];
  wire order_ok = setup_bot_off >= {6'b0, setup_top_off};
  wire setup_ok = top_ok && bot_ok && order_ok;
  wire accept   = setup_valid && setup_ok;

  wire [AW-1:0] new_top = setup_pc + AW'(setup_top_off);
  wire [AW-1:0] new_bot = setup_pc + AW'(setup_bot_off);

  wire [AW-1:0] woff   = fpc - top_q;
  wire [BW-1:0] widx   = woff[BW:1];
  wire          in_win = active && (fpc >= top_q) && (fpc <= bot_q) && (woff < WIN);
  wire          byp    = ivalid && ifill && (iidx == widx);
  wire          hit    = in_win && (bv[widx] || byp);
  wire          at_bot = active && (fpc == bot_q);
  wire          wrap   = at_bot && (cnt > CW'(1));

  assign next_pc     = !adv ? fpc : (wrap ? top_q : fpc + AW'(2));
  assign fetch_req   = adv && !hit;
  assign fetch_addr  = fpc;
  assign instr_valid = ivalid;
  assign instr_pc    = ipc;
  assign instr       = ihit ? lbuf[iidx] : mem_rdata;

  always_ff @(posedge clk) begin
    if (ivalid && ifill && active) lbuf[iidx] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpc       <= RESET_PC;
      top_q     <= '0;
      bot_q     <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      bv        <= '0;
      ivalid    <= 1'b0;
      ihit      <= 1'b0;
      ifill     <= 1'b0;
      iidx      <= '0;
      ipc       <= '0;
      setup_err <= 1'b0;
    end else begin
      setup_err <= setup_valid && !setup_ok;
      ivalid    <= adv;
      if (adv) begin
        fpc   <= next_pc;
        ipc   <= fpc;
        ihit  <= hit;
        ifill <= in_win && !hit;
        iidx  <= widx;
      end
      if (ivalid && ifill && active) bv[iidx] <= 1'b1;
      if (adv && at_bot) begin
        if (wrap) cnt <= cnt - CW'(1);
        else begin
          active <= 1'b0;
          bv     <= '0;
        end
      end
      if (accept) begin
        top_q  <= new_top;
        bot_q  <= new_bot;
        cnt    <= setup_count;
        active <= setup_count > CW'(1);
        bv     <= '0;
        ifill  <= 1'b0;
      end
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !active |=> fpc == $past(fpc) + AW'(2)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(fpc) && !instr_valid); // R11

  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && active && fpc == bot_q && cnt > CW'(1) |=> fpc == $past(top_q)); // R7

  AST_FALL_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    adv && active && fpc == bot_q && cnt <= CW'(1) && !setup_valid
    |=> !active && fpc == $past(bot_q) + AW'(2)); // R5

  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    setup_valid && !setup_ok |=> setup_err && $stable(top_q) && $stable(bot_q)); // R4
endmodule

// File: tb/loop_seq_bench.sv
`timescale 1ns/1ps
module loop_seq_bench;
  localparam int AW = 16, IW = 16, CW = 16;

  logic clk = 0, rst_n = 0, adv = 0, setup_valid = 0;
  logic [AW-1:0] setup_pc = '0;
  logic [5:0]    setup_top_off = '0;
  logic [11:0]   setup_bot_off = '0;
  logic [CW-1:0] setup_count = '0;
  logic setup_err, fetch_req, instr_valid;
  logic [AW-1:0] fetch_addr, next_pc, instr_pc;
  logic [IW-1:0] mem_rdata = '0, instr;

  always #2 clk = ~clk;

  loop_seq #(.AW(AW), .IW(IW), .CW(CW)) u_loop_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .setup_valid(setup_valid),
    .setup_pc(setup_pc), .setup_top_off(setup_top_off),
    .setup_bot_off(setup_bot_off), .setup_count(setup_count),
    .setup_err(setup_err), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .mem_rdata(mem_rdata), .next_pc(next_pc), .instr_valid(instr_valid),
    .instr_pc(instr_pc), .instr(instr));

  function automatic logic [IW-1:0] img(logic [AW-1:0] a);
    return (a * 16'd7) ^ 16'h3C5A;
  endfunction

  always @(posedge clk) mem_rdata <= fetch_req ? img(fetch_addr) : 16'hDEAD;

  int total = 0, bad = 0, fetch_cnt = 0;
  string cur_req = "R2";
  logic [AW-1:0] expq [$];
  logic [AW-1:0] cur_pc = '0;
  bit lpend = 0;
  int ltop, lbot, lcnt;
  bit prev_adv = 0;
  logic [AW-1:0] prev_next = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (fetch_req) fetch_cnt++;
      if (prev_adv) begin
        chk(instr_valid, "R7 no bubble", instr_valid, 1);
        chk(fetch_addr == prev_next, "R7 next_pc", fetch_addr, prev_next);
      end
      if (instr_valid) begin
        if (expq.size() == 0) chk(0, {cur_req, " unexpected issue"}, instr_pc, 0);
        else begin
          logic [AW-1:0] e;
          e = expq.pop_front();
          chk(instr_pc == e, {cur_req, " pc"}, instr_pc, e);
          chk(instr == img(e), {cur_req, " instr"}, instr, img(e));
        end
      end
      prev_adv  = adv;
      prev_next = next_pc;
    end
  end

  task automatic do_setup(int toff, int boff, int c, bit exp_err, string req);
    @(posedge clk); #1;
    setup_valid = 1; setup_pc = cur_pc;
    setup_top_off = 6'(toff); setup_bot_off = 12'(boff); setup_count = CW'(c);
    @(posedge clk); #1;
    setup_valid = 0;
    chk(setup_err == exp_err, req, setup_err, exp_err);
    @(posedge clk); #1;
    chk(setup_err == 0, {req, " err pulse"}, setup_err, 0);
    if (!exp_err) begin
      lpend = 1; ltop = int'(cur_pc) + toff; lbot = int'(cur_pc) + boff; lcnt = c;
    end
  endtask

  task automatic run_case(int tail, bit stall, string req);
    int n = 0, rep = 0, p;
    p = int'(cur_pc);
    cur_req = req;
    if (lpend) begin
      int iters, len;
      iters = (lcnt < 2) ? 1 : lcnt;
      len = (lbot - ltop) / 2 + 1;
      for (int a = p; a < ltop; a += 2) begin expq.push_back(AW'(a)); n++; end
      for (int k = 0; k < iters; k++)
        for (int a = ltop; a <= lbot; a += 2) begin expq.push_back(AW'(a)); n++; end
      rep = (lcnt < 2) ? 0 : (lcnt - 1) * ((len < 4) ? len : 4);
      p = lbot + 2;
      lpend = 0;
    end
    for (int k = 0; k < tail; k++) begin expq.push_back(AW'(p)); n++; p += 2; end
    fetch_cnt = 0;
    begin
      int k = 0, i = 0;
      while (k < n) begin
        @(posedge clk); #1;
        if (stall && (i % 3 == 2)) adv = 0;
        else begin adv = 1; k++; end
        i++;
      end
      @(posedge clk); #1; adv = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(expq.size() == 0, {req, " stream drained"}, expq.size(), 0);
    chk(fetch_cnt == n - rep, {req, " fetch count"}, fetch_cnt, n - rep);
    chk(fetch_addr == AW'(p), {req, " final pc"}, fetch_addr, p);
    cur_pc = AW'(p);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(fetch_addr == 0, "R1 fetch_addr", fetch_addr, 0);
    chk(instr_valid == 0, "R1 instr_valid", instr_valid, 0);
    chk(setup_err == 0, "R1 setup_err", setup_err, 0);
    rst_n = 1;

    run_case(5, 0, "R2 sequential");
    run_case(6, 1, "R11 stall sequential");
    repeat (2) @(posedge clk);
    #1;
    chk(fetch_addr == cur_pc, "R11 hold while stalled", fetch_addr, cur_pc);

    do_setup(4, 8, 5, 0, "R3 legal short");
    run_case(3, 0, "R8 short body x5");
    do_setup(0, 0, 4, 0, "R3 single");
    run_case(2, 0, "R8 one-instr body");
    do_setup(2, 8, 3, 0, "R3 four");
    run_case(2, 1, "R8 four-instr body stalled");
    do_setup(2, 14, 3, 0, "R3 long");
    run_case(2, 1, "R9 long body stalled");
    do_setup(0, 8, 2, 0, "R3 five");
    run_case(1, 0, "R9 five-instr body");

    do_setup(0, 6, 0, 0, "R3 count0");
    run_case(2, 0, "R6 count zero");
    do_setup(2, 4, 1, 0, "R3 count1");
    run_case(2, 0, "R6 count one");

    do_setup(2, 4, 2, 0, "R3 before bad");
    do_setup(3, 8, 9, 1, "R4 odd top");
    do_setup(4, 9, 9, 1, "R4 odd bottom");
    do_setup(-2, 8, 9, 1, "R4 negative top");
    do_setup(0, -4, 9, 1, "R4 negative bottom");
    do_setup(10, 6, 9, 1, "R4 bottom below top");
    run_case(2, 0, "R4 loop unchanged");

    do_setup(0, 2, 3, 0, "R3 first of pair");
    run_case(0, 0, "R10 first loop");
    do_setup(0, 4, 3, 0, "R3 second of pair");
    run_case(1, 0, "R10 store emptied");

    do_setup(30, 2046, 2, 0, "R3 max offsets");
    run_case(1, 0, "R5 max range loop");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule